// File: doc/BRIEF.md
# Address-Decoding Memory Bus Interconnect

This block connects one bus master to three slaves: an instruction memory window, a data memory window and a small register window for peripherals. The master issues requests on one channel with a valid/ready handshake. Each request carries a byte address, a write flag, an access size, write data and byte strobes. The interconnect decodes the address, passes the request to the one slave that owns it, and returns that slave's reply on a separate response channel. The response channel has its own valid/ready handshake and carries read data and an error flag.

Only one request is in flight at a time. Once a slave accepts a request, the interconnect remembers which slave it was. It listens to no other slave until the master has taken that slave's reply. The interconnect answers a request itself when no slave can take it: the address falls outside every window (the low boot aperture included), or the access is not aligned to its size. In that case it accepts the request at once and returns an error reply with zero data on the next cycle.

Slave index encoding, used on every per-slave vector: bit 0 is the instruction memory, bit 1 the data memory, bit 2 the peripheral window.

Top module: `mbx_interconnect`

## Requirements
- R1: An aligned request is routed by address, and at most one bit of `s_req_valid` is high in any cycle. Addresses 0x2000_0000 to 0x2000_FFFF go to slave bit 0. Addresses 0x8000_0000 to 0x8000_FFFF go to slave bit 1. Addresses 0x1000_0000 to 0x1000_0FFF go to slave bit 2.
- R2: The selected slave sees the master's address, write flag, size, write data and strobes unchanged. While the request waits, `m_req_ready` equals that slave's `s_req_ready`.
- R3: A request to an address outside all three windows raises no `s_req_valid` bit. This includes the boot aperture 0x0000_0000 to 0x0FFF_FFFF. Such a request is accepted in the cycle it is presented. In the next cycle `m_rsp_valid` and `m_rsp_err` are 1 and `m_rsp_rdata` is zero.
- R4: Size codes are 2'b00 byte, 2'b01 halfword and 2'b10 word. A halfword with address bit 0 set, a word with address bits 1:0 not zero, and the size code 2'b11 are all refused like an unmapped address (R3), even inside a window.
- R5: After a request is accepted, `m_req_ready` stays low and no `s_req_valid` bit is raised until the response handshake completes.
- R6: The reply comes only from the slave that accepted the request. Replies offered by any other slave are ignored. Only the accepting slave's `s_rsp_ready` bit follows `m_rsp_ready`, and the other bits stay low.
- R7: While `m_rsp_valid` is high and `m_rsp_ready` is low, the read data and error flag do not change, and `m_rsp_valid` stays high. This holds for the interconnect's own error replies and for slave replies that the slave itself holds.
- R8: After reset no request is outstanding: `m_rsp_valid` and all `s_req_valid` bits are 0 while the master is idle.
- R9: The interconnect waits any number of cycles for the selected slave, both to accept a request and to reply. It passes the slave's data and error flag through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Request accepted this cycle |
| m_req_addr | input | ADDR_W | Byte address |
| m_req_we | input | 1 | 1 write, 0 read |
| m_req_size | input | 2 | Access size code |
| m_req_wdata | input | DATA_W | Write data |
| m_req_wstrb | input | DATA_W/8 | Byte enables |
| m_rsp_valid | output | 1 | Response valid |
| m_rsp_ready | input | 1 | Master takes response |
| m_rsp_rdata | output | DATA_W | Read data |
| m_rsp_err | output | 1 | Fault flag |
| s_req_valid | output | 3 | Per-slave request valid |
| s_req_ready | input | 3 | Per-slave request ready |
| s_req_addr | output | ADDR_W | Address to slaves |
| s_req_we | output | 1 | Write flag to slaves |
| s_req_size | output | 2 | Size code to slaves |
| s_req_wdata | output | DATA_W | Write data to slaves |
| s_req_wstrb | output | DATA_W/8 | Strobes to slaves |
| s_rsp_valid | input | 3 | Per-slave response valid |
| s_rsp_ready | output | 3 | Per-slave response ready |
| s_rsp_rdata | input | 3*DATA_W | Per-slave read data, slave k at bits k*DATA_W |
| s_rsp_err | input | 3 | Per-slave fault flag |

## Verification
The master is driven with addresses at the first and last byte of each window and just past each window's end. Further addresses come from the boot aperture and from random points across the whole space. These patterns separate the three routing choices from each other and from the decode miss. Misaligned halfwords and words, and the unused size code, are presented inside valid windows: they show that alignment is refused independently of the window. The slave models stall their ready lines and reply after random delays, and the master stalls its response ready, so acceptance mirroring and reply holding are both exercised. While a request is in flight, slaves that are not selected offer bogus replies. A second request is also held at the master, which shows that foreign replies are ignored and that nothing else is accepted.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned NSLV  = 3;
    localparam int unsigned SEL_W = 2;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ERR  = 2'd2
    } trk_st_e;

    typedef struct packed {
        trk_st_e st;
        sel_t    sel;
    } trk_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned NREG   = 3,
    parameter logic [NREG*ADDR_W-1:0] REG_BASE = '0,
    parameter logic [NREG*8-1:0]      REG_LOG2 = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] BASE_G = REG_BASE[g*ADDR_W +: ADDR_W];
        localparam int unsigned       SPAN_G = int'(REG_LOG2[g*8 +: 8]);
        localparam logic [ADDR_W-1:0] MASK_G = {ADDR_W{1'b1}} << SPAN_G;
        assign hit[g] = ((addr & MASK_G) == (BASE_G & MASK_G));
    end
endmodule

// File: rtl/mbx_align.sv
module mbx_align
    import mbx_pkg::*;
#(
    parameter int unsigned STRB_W = 4
) (
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic       ok
);
    localparam bit HALF_FITS = (STRB_W >= 2);
    localparam bit WORD_FITS = (STRB_W >= 4);

    always_comb begin
        unique case (size_e'(size))
            SZ_BYTE: ok = 1'b1;
            SZ_HALF: ok = HALF_FITS && (addr_lo[0] == 1'b0);
            SZ_WORD: ok = WORD_FITS && (addr_lo == 2'b00);
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbx_track.sv
module mbx_track
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic m_req_valid,
    input  logic req_ok,
    input  sel_t req_sel,
    input  logic sel_ready,
    input  logic m_rsp_ready,
    input  logic sel_rsp_valid,
    output logic idle,
    output logic wait_act,
    output logic err_pend,
    output sel_t sel_q
);
    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.st)
            ST_IDLE: begin
                if (m_req_valid) begin
                    if (!req_ok) begin
                        st_d.st = ST_ERR;
                    end else if (sel_ready) begin
                        st_d.st  = ST_WAIT;
                        st_d.sel = req_sel;
                    end
                end
            end
            ST_WAIT: begin
                if (sel_rsp_valid && m_rsp_ready) st_d.st = ST_IDLE;
            end
            ST_ERR: begin
                if (m_rsp_ready) st_d.st = ST_IDLE;
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, sel: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign idle     = (st_q.st == ST_IDLE);
    assign wait_act = (st_q.st == ST_WAIT);
    assign err_pend = (st_q.st == ST_ERR);
    assign sel_q    = st_q.sel;
endmodule

// File: rtl/mbx_rsp_mux.sv
module mbx_rsp_mux
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                   wait_act,
    input  logic                   err_pend,
    input  sel_t                   sel_q,
    input  logic                   m_rsp_ready,
    input  logic [NSLV-1:0]        s_rsp_valid,
    input  logic [NSLV*DATA_W-1:0] s_rsp_rdata,
    input  logic [NSLV-1:0]        s_rsp_err,
    output logic [NSLV-1:0]        s_rsp_ready,
    output logic                   sel_rsp_valid,
    output logic                   m_rsp_valid,
    output logic [DATA_W-1:0]      m_rsp_rdata,
    output logic                   m_rsp_err
);
    logic [DATA_W-1:0] pick_data;
    logic              pick_err;

    always_comb begin
        sel_rsp_valid = 1'b0;
        pick_data     = '0;
        pick_err      = 1'b0;
        for (int k = 0; k < NSLV; k++) begin
            if (sel_q == SEL_W'(k)) begin
                sel_rsp_valid = s_rsp_valid[k];
                pick_data     = s_rsp_rdata[k*DATA_W +: DATA_W];
                pick_err      = s_rsp_err[k];
            end
        end
    end

    for (genvar g = 0; g < NSLV; g++) begin : g_rdy
        assign s_rsp_ready[g] = wait_act && (sel_q == SEL_W'(g)) && m_rsp_ready;
    end

    always_comb begin
        if (wait_act) begin
            m_rsp_valid = sel_rsp_valid;
            m_rsp_rdata = pick_data;
            m_rsp_err   = pick_err;
        end else begin
            m_rsp_valid = err_pend;
            m_rsp_rdata = '0;
            m_rsp_err   = err_pend;
        end
    end
endmodule

// File: rtl/mbx_interconnect.sv
module mbx_interconnect
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter logic [ADDR_W-1:0] IMEM_BASE = 32'h2000_0000,
    parameter int unsigned       IMEM_LOG2 = 16,
    parameter logic [ADDR_W-1:0] DMEM_BASE = 32'h8000_0000,
    parameter int unsigned       DMEM_LOG2 = 16,
    parameter logic [ADDR_W-1:0] MMIO_BASE = 32'h1000_0000,
    parameter int unsigned       MMIO_LOG2 = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   m_req_valid,
    output logic                   m_req_ready,
    input  logic [ADDR_W-1:0]      m_req_addr,
    input  logic                   m_req_we,
    input  logic [1:0]             m_req_size,
    input  logic [DATA_W-1:0]      m_req_wdata,
    input  logic [DATA_W/8-1:0]    m_req_wstrb,
    output logic                   m_rsp_valid,
    input  logic                   m_rsp_ready,
    output logic [DATA_W-1:0]      m_rsp_rdata,
    output logic                   m_rsp_err,
    output logic [NSLV-1:0]        s_req_valid,
    input  logic [NSLV-1:0]        s_req_ready,
    output logic [ADDR_W-1:0]      s_req_addr,
    output logic                   s_req_we,
    output logic [1:0]             s_req_size,
    output logic [DATA_W-1:0]      s_req_wdata,
    output logic [DATA_W/8-1:0]    s_req_wstrb,
    input  logic [NSLV-1:0]        s_rsp_valid,
    output logic [NSLV-1:0]        s_rsp_ready,
    input  logic [NSLV*DATA_W-1:0] s_rsp_rdata,
    input  logic [NSLV-1:0]        s_rsp_err
);
    localparam int unsigned STRB_W = DATA_W / 8;
    localparam logic [NSLV*ADDR_W-1:0] REG_BASE = {MMIO_BASE, DMEM_BASE, IMEM_BASE};
    localparam logic [NSLV*8-1:0] REG_LOG2 = {8'(MMIO_LOG2), 8'(DMEM_LOG2), 8'(IMEM_LOG2)};

    logic [NSLV-1:0] hit;
    logic            any_hit;
    logic            align_ok;
    logic            req_ok;
    sel_t            req_sel;
    logic            sel_ready;
    logic            idle;
    logic            wait_act;
    logic            err_pend;
    sel_t            sel_q;
    logic            sel_rsp_valid;

    mbx_decode #(
        .ADDR_W  (ADDR_W),
        .NREG    (NSLV),
        .REG_BASE(REG_BASE),
        .REG_LOG2(REG_LOG2)
    ) u_decode (
        .addr(m_req_addr),
        .hit (hit)
    );

    mbx_align #(
        .STRB_W(STRB_W)
    ) u_align (
        .size   (m_req_size),
        .addr_lo(m_req_addr[1:0]),
        .ok     (align_ok)
    );

    always_comb begin
        req_sel = '0;
        for (int k = 0; k < NSLV; k++) begin
            if (hit[k]) req_sel = SEL_W'(k);
        end
    end

    assign any_hit   = |hit;
    assign req_ok    = any_hit && align_ok;
    assign sel_ready = |(s_req_ready & hit);

    mbx_track u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .m_req_valid  (m_req_valid),
        .req_ok       (req_ok),
        .req_sel      (req_sel),
        .sel_ready    (sel_ready),
        .m_rsp_ready  (m_rsp_ready),
        .sel_rsp_valid(sel_rsp_valid),
        .idle         (idle),
        .wait_act     (wait_act),
        .err_pend     (err_pend),
        .sel_q        (sel_q)
    );

    for (genvar g = 0; g < NSLV; g++) begin : g_req
        assign s_req_valid[g] = idle && m_req_valid && req_ok && hit[g];
    end

    assign m_req_ready = idle && (!req_ok || sel_ready);
    assign s_req_addr  = m_req_addr;
    assign s_req_we    = m_req_we;
    assign s_req_size  = m_req_size;
    assign s_req_wdata = m_req_wdata;
    assign s_req_wstrb = m_req_wstrb;

    mbx_rsp_mux #(
        .DATA_W(DATA_W)
    ) u_rsp (
        .wait_act     (wait_act),
        .err_pend     (err_pend),
        .sel_q        (sel_q),
        .m_rsp_ready  (m_rsp_ready),
        .s_rsp_valid  (s_rsp_valid),
        .s_rsp_rdata  (s_rsp_rdata),
        .s_rsp_err    (s_rsp_err),
        .s_rsp_ready  (s_rsp_ready),
        .sel_rsp_valid(sel_rsp_valid),
        .m_rsp_valid  (m_rsp_valid),
        .m_rsp_rdata  (m_rsp_rdata),
        .m_rsp_err    (m_rsp_err)
    );
endmodule

// File: rtl/mbx_interconnect_chk.sv
module mbx_interconnect_chk
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_req_valid,
    input logic              m_req_ready,
    input logic              m_rsp_valid,
    input logic              m_rsp_ready,
    input logic [DATA_W-1:0] m_rsp_rdata,
    input logic              m_rsp_err,
    input logic [NSLV-1:0]   s_req_valid,
    input logic [NSLV-1:0]   s_req_ready,
    input logic [NSLV-1:0]   s_rsp_ready
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (m_req_valid && m_req_ready) begin
            busy_q <= 1'b1;
        end else if (m_rsp_valid && m_rsp_ready) begin
            busy_q <= 1'b0;
        end
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_req_valid)); // R1

    AST_READY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_req_valid) |-> (m_req_ready == |(s_req_valid & s_req_ready))); // R2

    AST_MISS_ERR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_valid && m_req_ready && (s_req_valid == '0))
        |=> (m_rsp_valid && m_rsp_err && (m_rsp_rdata == '0))); // R3

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (!m_req_ready && (s_req_valid == '0))); // R5

    AST_RSP_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_rsp_ready)); // R6

    AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        m_rsp_valid |-> busy_q); // R8

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rsp_valid && !m_rsp_ready)
        |=> (m_rsp_valid && $stable(m_rsp_rdata) && $stable(m_rsp_err))); // R7
endmodule

bind mbx_interconnect mbx_interconnect_chk #(
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_req_valid(m_req_valid),
    .m_req_ready(m_req_ready),
    .m_rsp_valid(m_rsp_valid),
    .m_rsp_ready(m_rsp_ready),
    .m_rsp_rdata(m_rsp_rdata),
    .m_rsp_err  (m_rsp_err),
    .s_req_valid(s_req_valid),
    .s_req_ready(s_req_ready),
    .s_rsp_ready(s_rsp_ready)
);

// File: tb/mbx_interconnect_tb.sv
module mbx_interconnect_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req_valid = 1'b0;
    logic        m_req_ready;
    logic [31:0] m_req_addr = '0;
    logic        m_req_we = 1'b0;
    logic [1:0]  m_req_size = '0;
    logic [31:0] m_req_wdata = '0;
    logic [3:0]  m_req_wstrb = '0;
    logic        m_rsp_valid;
    logic        m_rsp_ready = 1'b0;
    logic [31:0] m_rsp_rdata;
    logic        m_rsp_err;
    logic [2:0]  s_req_valid;
    logic [2:0]  s_req_ready;
    logic [31:0] s_req_addr;
    logic        s_req_we;
    logic [1:0]  s_req_size;
    logic [31:0] s_req_wdata;
    logic [3:0]  s_req_wstrb;
    logic [2:0]  s_rsp_valid;
    logic [2:0]  s_rsp_ready;
    logic [95:0] s_rsp_rdata;
    logic [2:0]  s_rsp_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_interconnect u_dut (
        .clk(clk), .rst_n(rst_n),
        .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
        .m_req_addr(m_req_addr), .m_req_we(m_req_we), .m_req_size(m_req_size),
        .m_req_wdata(m_req_wdata), .m_req_wstrb(m_req_wstrb),
        .m_rsp_valid(m_rsp_valid), .m_rsp_ready(m_rsp_ready),
        .m_rsp_rdata(m_rsp_rdata), .m_rsp_err(m_rsp_err),
        .s_req_valid(s_req_valid), .s_req_ready(s_req_ready),
        .s_req_addr(s_req_addr), .s_req_we(s_req_we), .s_req_size(s_req_size),
        .s_req_wdata(s_req_wdata), .s_req_wstrb(s_req_wstrb),
        .s_rsp_valid(s_rsp_valid), .s_rsp_ready(s_rsp_ready),
        .s_rsp_rdata(s_rsp_rdata), .s_rsp_err(s_rsp_err)
    );

    // ---------------- reference functions ----------------
    function automatic bit exp_aligned(input logic [31:0] a, input logic [1:0] sz);
        return (sz == 2'b00) || (sz == 2'b01 && !a[0]) || (sz == 2'b10 && a[1:0] == 2'b00);
    endfunction

    function automatic int exp_slave(input logic [31:0] a, input logic [1:0] sz);
        if (!exp_aligned(a, sz)) return 3;
        if (a >= 32'h2000_0000 && a <= 32'h2000_FFFF) return 0;
        if (a >= 32'h8000_0000 && a <= 32'h8000_FFFF) return 1;
        if (a >= 32'h1000_0000 && a <= 32'h1000_0FFF) return 2;
        return 3;
    endfunction

    function automatic logic [31:0] slv_data(input int i, input logic [31:0] a,
                                             input logic we, input logic [31:0] wd);
        return {4'(i + 1), a[27:0]} ^ (we ? wd : 32'h0);
    endfunction

    function automatic logic slv_err(input int i, input logic [31:0] a);
        return (i == 2) && (a[11:8] == 4'hF);
    endfunction

    // ---------------- slave models ----------------
    logic [2:0]  pend, rsp_v, rdy_rand, err_q;
    logic [1:0]  lat [3];
    logic [31:0] cap_addr [3];
    logic [31:0] cap_wdata [3];
    logic [31:0] rd_q [3];
    logic        cap_we [3];
    logic [1:0]  cap_size [3];
    logic [3:0]  cap_strb [3];
    int          cap_cnt [3];
    logic        rogue = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0; rsp_v <= '0; rdy_rand <= '0; err_q <= '0;
            for (int i = 0; i < 3; i++) begin
                cap_cnt[i] <= 0; lat[i] <= '0; rd_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                rdy_rand[i] <= (($urandom % 3) != 0);
                if (s_req_valid[i] && s_req_ready[i]) begin
                    pend[i]      <= 1'b1;
                    lat[i]       <= 2'($urandom % 4);
                    cap_addr[i]  <= s_req_addr;
                    cap_we[i]    <= s_req_we;
                    cap_size[i]  <= s_req_size;
                    cap_wdata[i] <= s_req_wdata;
                    cap_strb[i]  <= s_req_wstrb;
                    cap_cnt[i]   <= cap_cnt[i] + 1;
                end else if (pend[i] && !rsp_v[i]) begin
                    if (lat[i] == 2'd0) begin
                        rsp_v[i] <= 1'b1;
                        rd_q[i]  <= slv_data(i, cap_addr[i], cap_we[i], cap_wdata[i]);
                        err_q[i] <= slv_err(i, cap_addr[i]);
                    end else begin
                        lat[i] <= lat[i] - 2'd1;
                    end
                end else if (rsp_v[i] && s_rsp_ready[i]) begin
                    rsp_v[i] <= 1'b0;
                    pend[i]  <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < 3; i++) begin
            s_req_ready[i] = rdy_rand[i] & ~pend[i];
            s_rsp_valid[i] = rsp_v[i] | (rogue & ~pend[i]);
            s_rsp_rdata[i*32 +: 32] = rsp_v[i] ? rd_q[i] : 32'hBADB_AD00;
            s_rsp_err[i] = rsp_v[i] ? err_q[i] : 1'b1;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic txn(input logic [31:0] a, input logic we, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [3:0] st);
        int e;
        int c0 [3];
        int n;
        bit bad_route, bad5, bad6, bad7, first, done;
        logic [31:0] got_d, exp_d;
        logic got_e, exp_e;
        string mtag;
        e = exp_slave(a, sz);
        mtag = exp_aligned(a, sz) ? "R3" : "R4";
        for (int i = 0; i < 3; i++) c0[i] = cap_cnt[i];
        rogue = ($urandom % 2) == 1;

        @(negedge clk);
        m_req_addr = a; m_req_we = we; m_req_size = sz;
        m_req_wdata = wd; m_req_wstrb = st; m_req_valid = 1'b1;
        #1;
        n = 0; bad_route = 0;
        while (1) begin
            if (e != 3) begin
                if (s_req_valid != 3'(1 << e) || s_req_addr != a || s_req_we != we ||
                    s_req_size != sz || s_req_wdata != wd || s_req_wstrb != st ||
                    m_req_ready != s_req_ready[e]) bad_route = 1;
            end else if (s_req_valid != 3'b000 || !m_req_ready) begin
                bad_route = 1;
            end
            if (m_req_ready || n >= 100) break;
            @(negedge clk); #1; n++;
        end
        if (e != 3) check(!bad_route && n < 100, "R1 R2 routing and ready mirror", {29'd0, s_req_valid}, 32'(1 << e));
        else        check(!bad_route, {mtag, " refused request accepted at once with no slave"}, {29'd0, s_req_valid}, 32'h0);

        // accepted at the coming edge; keep a second request pending (R5 probe)
        @(negedge clk);
        m_req_addr = 32'h8000_0010; m_req_size = 2'b10; m_req_we = 1'b0;
        #1;
        if (e == 3)
            check(m_rsp_valid && m_rsp_err && m_rsp_rdata == 32'h0,
                  {mtag, " error reply one cycle after acceptance"}, m_rsp_rdata, 32'h0);

        exp_d = (e == 3) ? 32'h0 : slv_data(e, a, we, wd);
        exp_e = (e == 3) ? 1'b1 : slv_err(e, a);
        n = 0; first = 1; done = 0; bad5 = 0; bad6 = 0; bad7 = 0;
        got_d = '0; got_e = 1'b0;
        while (!done) begin
            if (m_req_ready || s_req_valid != 3'b000) bad5 = 1;
            if (m_rsp_valid) begin
                if (first) begin
                    got_d = m_rsp_rdata; got_e = m_rsp_err; first = 0;
                end else if (m_rsp_rdata != got_d || m_rsp_err != got_e) begin
                    bad7 = 1;
                end
                if (($urandom % 2) == 0) begin
                    m_rsp_ready = 1'b1;
                    #1;
                    if (s_rsp_ready != ((e == 3) ? 3'b000 : 3'(1 << e))) bad6 = 1;
                    done = 1;
                end
            end else if (!first) begin
                bad7 = 1;
            end
            if (!done) begin
                if (n >= 100) begin
                    check(0, "R9 response watchdog", 32'(n), 32'd100);
                    done = 1;
                end
                @(negedge clk); #1; n++;
            end
        end
        @(negedge clk);
        m_rsp_ready = 1'b0; m_req_valid = 1'b0;
        #1;
        check(got_d == exp_d && got_e == exp_e, "R6 R9 reply data and error", got_d, exp_d);
        check(!bad5, "R5 nothing accepted while busy", {31'd0, bad5}, 32'h0);
        check(!bad6, "R6 response ready only to owner", {29'd0, s_rsp_ready}, 32'h0);
        check(!bad7, "R7 reply held while stalled", got_d, exp_d);
        for (int i = 0; i < 3; i++) begin
            check(cap_cnt[i] == c0[i] + ((i == e) ? 1 : 0),
                  "R1 R3 slave capture count", 32'(cap_cnt[i]), 32'(c0[i] + ((i == e) ? 1 : 0)));
        end
        if (e != 3)
            check(cap_addr[e] == a && cap_we[e] == we && cap_size[e] == sz &&
                  cap_wdata[e] == wd && cap_strb[e] == st,
                  "R2 fields seen by slave", cap_addr[e], a);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check(m_rsp_valid == 1'b0 && s_req_valid == 3'b000, "R8 quiet during reset", {31'd0, m_rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(m_rsp_valid == 1'b0 && s_req_valid == 3'b000, "R8 quiet after reset", {31'd0, m_rsp_valid}, 32'h0);

        // directed boundaries
        txn(32'h2000_0000, 1'b0, 2'b10, 32'h0, 4'hF);
        txn(32'h2000_FFFC, 1'b1, 2'b10, 32'h1234_5678, 4'hF);
        txn(32'h2001_0000, 1'b0, 2'b10, 32'h0, 4'hF);
        txn(32'h8000_0000, 1'b1, 2'b00, 32'h0000_00AB, 4'h1);
        txn(32'h8000_FFFE, 1'b0, 2'b01, 32'h0, 4'hC);
        txn(32'h8001_0000, 1'b0, 2'b00, 32'h0, 4'h1);
        txn(32'h1000_0000, 1'b1, 2'b10, 32'hCAFE_F00D, 4'hF);
        txn(32'h1000_0FFF, 1'b0, 2'b00, 32'h0, 4'h8);
        txn(32'h1000_0F00, 1'b0, 2'b10, 32'h0, 4'hF);
        txn(32'h1000_1000, 1'b0, 2'b10, 32'h0, 4'hF);
        txn(32'h0000_0000, 1'b0, 2'b10, 32'h0, 4'hF);
        txn(32'h0FFF_FFFC, 1'b1, 2'b10, 32'h5555_AAAA, 4'hF);
        txn(32'hFFFF_FFFC, 1'b0, 2'b10, 32'h0, 4'hF);
        // alignment (R4)
        txn(32'h8000_0002, 1'b0, 2'b10, 32'h0, 4'hF);
        txn(32'h8000_0001, 1'b1, 2'b01, 32'h0, 4'h6);
        txn(32'h2000_0000, 1'b0, 2'b11, 32'h0, 4'hF);
        txn(32'h8000_0002, 1'b0, 2'b01, 32'h0, 4'hC);
        txn(32'h2000_0003, 1'b0, 2'b00, 32'h0, 4'h8);

        // constrained random
        for (int t = 0; t < 400; t++) begin
            logic [31:0] a;
            logic [1:0]  sz;
            int r;
            r = $urandom % 5;
            case (r)
                0: a = 32'h2000_0000 | ($urandom & 32'h0000_FFFF);
                1: a = 32'h8000_0000 | ($urandom & 32'h0000_FFFF);
                2: a = 32'h1000_0000 | ($urandom & 32'h0000_0FFF);
                3: a = $urandom & 32'h0FFF_FFFF;
                default: a = $urandom;
            endcase
            sz = 2'($urandom % 4);
            if (($urandom % 4) != 0) begin
                if (sz == 2'b01) a[0] = 1'b0;
                if (sz == 2'b10) a[1:0] = 2'b00;
                if (sz == 2'b11) sz = 2'b10;
                if (sz == 2'b10) a[1:0] = 2'b00;
            end
            txn(a, 1'($urandom), sz, $urandom, 4'($urandom));
        end

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R9 global watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule